// File: doc/BRIEF.md
# Frame sync pulse generator

This block derives two frame-rate timing signals from one system clock: a fast frame output (8 kHz with the default 2.048 MHz reference) and a slow frame output at one quarter of that rate (2 kHz). A single counter advances once per reference tick. Its low bits time the fast frame and its full width times the slow frame, so every slow frame starts on the same tick as a fast frame.

Each output has its own enable, inversion and shape controls. The shape is either a half-high square wave or a pulse one reference period wide. One shared placement control puts the pulse at the start of the frame (where the square wave rises) or at mid-frame (where it falls).

A one-cycle resync strobe forces the counter back to frame start. This lets both outputs be realigned to an external frame event that upstream logic has accepted. Both outputs come straight from flip-flops, so neither can glitch.

Top module: `frame_sync_gen`

## Requirements
- R1: While reset is asserted both outputs are 0, even with inversion on. The counter resets to all ones, so the first reference tick after the internal reset release enters frame position 0.
- R2: For the fast output in square mode, not inverted and enabled, the output is 1 for positions 0 to 2^(FRAME_W-1)-1 of its 2^FRAME_W-tick frame and 0 for the rest. The frame position is the low FRAME_W counter bits.
- R3: The slow output in square mode has a frame of 2^(FRAME_W+RATIO_W) ticks and is 1 in the first half of it. A rising slow edge always coincides with the fast output being high at fast frame position 0.
- R4: In pulse mode with pulse_late=0, an output is 1 only while its frame position is 0. This lasts exactly one reference period.
- R5: In pulse mode with pulse_late=1, the fast output pulses at position 2^(FRAME_W-1) and the slow output at position 2^(FRAME_W+RATIO_W-1). Each pulse is one reference period wide.
- R6: Inversion is applied after shape and placement, so an enabled, inverted output is the exact complement of its non-inverted form.
- R7: A disabled output is 0 whatever its inversion, shape and placement settings.
- R8: A resync strobe sampled at a clock edge sets the counter to 0 at that edge, overriding ref_tick. The outputs show frame position 0 from the following edge onward.
- R9: On a clock edge with ref_tick=0 and no resync, the counter holds. Each output is a registered function of the counter with a one-clock lag, so pulses and square phases stretch over the whole reference period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_tick | input | 1 | One-clock enable marking each reference clock period |
| resync | input | 1 | One-clock strobe that restarts both frames at position 0 |
| pulse_late | input | 1 | Pulse placement: 0 at frame start, 1 at mid-frame |
| f8_en | input | 1 | Fast output enable |
| f8_inv | input | 1 | Fast output inversion |
| f8_pulse | input | 1 | Fast output shape: 0 square, 1 pulse |
| f2_en | input | 1 | Slow output enable |
| f2_inv | input | 1 | Slow output inversion |
| f2_pulse | input | 1 | Slow output shape: 0 square, 1 pulse |
| f8_sync | output | 1 | Fast frame sync output |
| f2_sync | output | 1 | Slow frame sync output |

## Verification
The bench uses a small configuration: 8-tick fast frames and 32-tick slow frames. It sweeps all 128 combinations of the seven control bits twice. The first pass ticks on every clock and separates the square, early-pulse, late-pulse, inverted and disabled encodings for both outputs across more than one slow frame. The second pass ticks on every third clock, which shows whether pulses and half-periods stretch over a full reference period rather than a single clock. Every run also strobes resync in mid-frame, and the following cycles show whether both outputs restart at frame position 0 and whether the slow frame stays tied to the fast one.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

  // Per-output control word
  typedef struct packed {
    logic en;     // output enabled
    logic inv;    // polarity flip, applied last
    logic pulse;  // 1: single reference period pulse, 0: square wave
  } fs_ctrl_t;

  localparam int NUM_OUT = 2;

endpackage

// File: rtl/fsg_rst_sync.sv
module fsg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage_q;
  logic stage_d;
  logic out_d;

  always_comb begin
    stage_d = 1'b1;
    out_d   = stage_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= stage_d;
      rst_sync_n <= out_d;
    end
  end

endmodule

// File: rtl/fsg_divider.sv
module fsg_divider #(
  parameter int FRAME_W = 8,
  parameter int RATIO_W = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tick,
  input  logic                       resync,
  output logic [FRAME_W+RATIO_W-1:0] cnt_q
);

  localparam int CNT_W = FRAME_W + RATIO_W;
  localparam logic [CNT_W-1:0] STEP = CNT_W'(1);

  logic [CNT_W-1:0] cnt_d;
  logic             cnt_ce;

  // Next-state: resync wins over the reference tick
  always_comb begin
    cnt_ce = tick | resync;
    cnt_d  = cnt_q;
    if (resync) begin
      cnt_d = '0;
    end else if (tick) begin
      cnt_d = cnt_q + STEP;
    end
  end

  // Reset to all ones so the first tick lands on frame position 0
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '1;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/fsg_shaper.sv
module fsg_shaper #(
  parameter int W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [W-1:0]       pos_cnt,
  input  fsg_pkg::fs_ctrl_t  ctrl,
  input  logic               pulse_late,
  output logic               fs_q
);

  localparam logic [W-1:0] MID = {1'b1, {(W-1){1'b0}}};

  logic sq_form;
  logic at_start;
  logic at_mid;
  logic shaped;
  logic fs_d;
  logic fs_ce;

  always_comb begin
    sq_form  = ~pos_cnt[W-1];
    at_start = (pos_cnt == '0);
    at_mid   = (pos_cnt == MID);
    if (ctrl.pulse) begin
      shaped = pulse_late ? at_mid : at_start;
    end else begin
      shaped = sq_form;
    end
    // polarity flip after shaping, enable gates everything
    fs_d  = ctrl.en & (shaped ^ ctrl.inv);
    fs_ce = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q <= 1'b0;
    end else if (fs_ce) begin
      fs_q <= fs_d;
    end
  end

endmodule

// File: rtl/frame_sync_gen.sv
module frame_sync_gen #(
  parameter int FRAME_W = 8,
  parameter int RATIO_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_tick,
  input  logic resync,
  input  logic pulse_late,
  input  logic f8_en,
  input  logic f8_inv,
  input  logic f8_pulse,
  input  logic f2_en,
  input  logic f2_inv,
  input  logic f2_pulse,
  output logic f8_sync,
  output logic f2_sync
);

  import fsg_pkg::*;

  localparam int CNT_W = FRAME_W + RATIO_W;

  logic             rst_int_n;
  logic [CNT_W-1:0] cnt_q;
  fs_ctrl_t         ctrl   [NUM_OUT];
  logic [NUM_OUT-1:0] fs_vec;

  fsg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  fsg_divider #(
    .FRAME_W (FRAME_W),
    .RATIO_W (RATIO_W)
  ) u_div (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .tick   (ref_tick),
    .resync (resync),
    .cnt_q  (cnt_q)
  );

  always_comb begin
    ctrl[0] = '{en: f8_en, inv: f8_inv, pulse: f8_pulse};
    ctrl[1] = '{en: f2_en, inv: f2_inv, pulse: f2_pulse};
  end

  // Output g looks at the low FRAME_W + g*RATIO_W counter bits
  for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
    localparam int W = FRAME_W + g * RATIO_W;
    fsg_shaper #(
      .W (W)
    ) u_shp (
      .clk        (clk),
      .rst_n      (rst_int_n),
      .pos_cnt    (cnt_q[W-1:0]),
      .ctrl       (ctrl[g]),
      .pulse_late (pulse_late),
      .fs_q       (fs_vec[g])
    );
  end

  assign f8_sync = fs_vec[0];
  assign f2_sync = fs_vec[1];

endmodule

// File: rtl/fsg_checker.sv
module fsg_checker #(
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ref_tick,
  input logic             resync,
  input logic             f8_en,
  input logic             f8_inv,
  input logic             f8_pulse,
  input logic             f2_en,
  input logic             f2_inv,
  input logic             f2_pulse,
  input logic             f8_sync,
  input logic             f2_sync,
  input logic [CNT_W-1:0] cnt
);

  logic both_square;
  assign both_square = f8_en & ~f8_inv & ~f8_pulse & f2_en & ~f2_inv & ~f2_pulse;

  AST_RESYNC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> (cnt == '0)); // R8

  AST_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ref_tick && !resync) |=> $stable(cnt)); // R9

  AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_tick && !resync) |=> (cnt == CNT_W'($past(cnt) + CNT_W'(1)))); // R2

  AST_FAST_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !f8_en |=> !f8_sync); // R7

  AST_SLOW_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !f2_en |=> !f2_sync); // R7

  AST_SLOW_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(f2_sync) && $past(both_square) && $past(both_square, 2)) |-> f8_sync); // R3

endmodule

bind frame_sync_gen fsg_checker #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_int_n),
  .ref_tick (ref_tick),
  .resync   (resync),
  .f8_en    (f8_en),
  .f8_inv   (f8_inv),
  .f8_pulse (f8_pulse),
  .f2_en    (f2_en),
  .f2_inv   (f2_inv),
  .f2_pulse (f2_pulse),
  .f8_sync  (f8_sync),
  .f2_sync  (f2_sync),
  .cnt      (cnt_q)
);

// File: tb/frame_sync_gen_test.sv
module frame_sync_gen_test;

  localparam int FW = 3;
  localparam int RW = 2;
  localparam int CW = FW + RW;
  localparam int PER = 1 << CW;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, ref_tick, resync, pulse_late;
  logic f8_en, f8_inv, f8_pulse, f2_en, f2_inv, f2_pulse;
  logic f8_sync, f2_sync;

  int total = 0;
  int bad = 0;
  int m = 0;
  bit done = 0;

  frame_sync_gen #(.FRAME_W(FW), .RATIO_W(RW)) uut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .resync(resync),
    .pulse_late(pulse_late),
    .f8_en(f8_en), .f8_inv(f8_inv), .f8_pulse(f8_pulse),
    .f2_en(f2_en), .f2_inv(f2_inv), .f2_pulse(f2_pulse),
    .f8_sync(f8_sync), .f2_sync(f2_sync)
  );

  function automatic bit model_fs(int c, int w, bit en, bit inv, bit pul, bit late);
    int per = 1 << w;
    int half = per / 2;
    int pos = c % per;
    bit sh;
    if (pul) sh = late ? (pos == half) : (pos == 0);
    else     sh = (pos < half);
    return en ? (sh ^ inv) : 1'b0;
  endfunction

  function automatic string tag_of(bit slow, bit en, bit inv, bit pul, bit late,
                                   bit stretched, bit first);
    if (!en) return "R7";
    if (first) return "R8";
    if (stretched) return "R9";
    if (pul) return late ? "R5" : "R4";
    if (inv) return "R6";
    return slow ? "R3" : "R2";
  endfunction

  task automatic check(string req, string what, logic got, bit exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s got=%b exp=%b (m=%0d)", req, what, got, exp, m);
    end
  endtask

  // Drive one clock; outputs after the edge reflect the count before it
  task automatic step(bit tk, bit rs, bit do_chk, bit stretched, bit first);
    bit e8, e2;
    ref_tick = tk;
    resync = rs;
    @(posedge clk);
    e8 = model_fs(m, FW, f8_en, f8_inv, f8_pulse, pulse_late);
    e2 = model_fs(m, CW, f2_en, f2_inv, f2_pulse, pulse_late);
    if (rs) m = 0;
    else if (tk) m = (m + 1) % PER;
    @(negedge clk);
    if (do_chk) begin
      check(tag_of(0, f8_en, f8_inv, f8_pulse, pulse_late, stretched, first), "fast", f8_sync, e8);
      check(tag_of(1, f2_en, f2_inv, f2_pulse, pulse_late, stretched, first), "slow", f2_sync, e2);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    ref_tick = 1'b1;
    resync = 1'b0;
    pulse_late = 1'b0;
    f8_en = 1'b1; f8_inv = 1'b1; f8_pulse = 1'b0;
    f2_en = 1'b1; f2_inv = 1'b1; f2_pulse = 1'b0;
    // R1: outputs stay low in reset even though inversion is on
    repeat (3) begin
      @(negedge clk);
      check("R1", "fast in reset", f8_sync, 1'b0);
      check("R1", "slow in reset", f2_sync, 1'b0);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int c = 0; c < 256; c++) begin
      bit stretch;
      bit last_rs;
      stretch = c[7];
      {pulse_late, f2_pulse, f2_inv, f2_en, f8_pulse, f8_inv, f8_en} = c[6:0];
      step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
      last_rs = 1'b1;
      for (int k = 0; k < 40; k++) begin
        bit tk, rs;
        tk = stretch ? (k % 3 == 0) : 1'b1;
        rs = (k == 21);
        step(tk, rs, 1'b1, stretch, last_rs);
        last_rs = rs;
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule